// File: doc/BRIEF.md
# Programmable Flag Offset Load and Readback Port

This block owns the two threshold offsets used by a dual-clock FIFO's partial flags: the almost-empty offset and the almost-full offset. A producer loads them over the FIFO's own write data bus, and a consumer reads them back over the FIFO's own read data bus. A shared active-low load strobe selects between offset traffic and ordinary FIFO traffic. While load is low, a write-enable moves the word into an offset register. While load is high, the block raises a steering strobe that sends the write to FIFO storage instead.

The write side and the read side each keep their own register pointer. Each pointer alternates between the empty and the full offset. A load sequence can therefore be split across any number of ordinary FIFO accesses and still land in the right register. Per-flag validity bits tell the downstream flag arithmetic when a freshly loaded threshold may be trusted.

The output data register is shared between offset readback and FIFO reads. A partial reset clears that register and leaves both pointers where they are. A master reset returns everything to its default state.

Top module: `offset_reg_port`

## Requirements
- R1: On a rising `wr_clk` edge with `ld_n` low and `wen_n` low, the low OW bits of `wdata` are stored in the offset selected by the write pointer, and the pointer then flips. The first load goes to the empty offset (`empty_ofs`), the second to the full offset (`full_ofs`), and the third to the empty offset again.
- R2: On a rising `rd_clk` edge with `ld_n` low, `ren_n` low and `prst_n` high, `q` takes the offset selected by the read pointer, and the read pointer then flips. The order is empty, full, empty. The offset sits in `q[OW-1:0]`, and `q[DW-1:OW]` reads zero.
- R3: The write pointer moves only on offset loads, and the read pointer moves only on offset reads. Neither pointer is affected by the other side's traffic.
- R4: While `mrst_n` is low (asynchronous, active low):
  - both pointers select the empty offset;
  - the offsets take `EMPTY_DEF` and `FULL_DEF`;
  - both validity bits are 1;
  - `q` is 0.
- R5: A low `prst_n` at a rising `rd_clk` edge clears `q` to 0. It leaves both pointers and both offsets unchanged, and an offset read requested in that cycle is ignored.
- R6: `fifo_wr` equals (`ld_n` high and `wen_n` low), combinationally. Neither that state nor `ld_n` low with `wen_n` high changes an offset. The next load after such a pause goes to the next register in sequence.
- R7: `fifo_rd` equals (`ld_n` high and `ren_n` low), combinationally. With `prst_n` high, a rising `rd_clk` edge in that state loads `fifo_q` into `q`, overwriting any previous readback. After a pause, offset reading resumes at the next register in sequence.
- R8: A load into the empty offset sets `empty_ofs_vld` and clears `full_ofs_vld`, because a new programming pass has begun. A load into the full offset sets `full_ofs_vld`.
- R9: With `prst_n` high and neither an offset read nor a FIFO read at a rising `rd_clk` edge, `q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous to rd_clk, active low |
| ld_n | input | 1 | Offset access select, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| wdata | input | DW | Write data bus |
| fifo_q | input | DW | Word delivered by FIFO storage on a FIFO read |
| q | output | DW | Read data bus register |
| fifo_wr | output | 1 | Write steered to FIFO storage |
| fifo_rd | output | 1 | Read steered to FIFO storage |
| empty_ofs | output | OW | Almost-empty offset |
| full_ofs | output | OW | Almost-full offset |
| empty_ofs_vld | output | 1 | Almost-empty offset valid |
| full_ofs_vld | output | 1 | Almost-full offset valid |

## Verification
Suppose a write pointer has slipped. The next load then lands in the wrong register, and `empty_ofs` or `full_ofs` shows the wrong value one `wr_clk` edge later. The validity bits also disagree from that same edge. A slipped read pointer shows the other offset on `q` at the very next readback edge. A stray update of `q` is visible on the `rd_clk` edge where it happens, and so is a pointer disturbed by the partial reset. A reference model advanced on every edge of both clocks catches each of these within one cycle of its own domain.

// File: rtl/offset_port_pkg.sv
package offset_port_pkg;

  // number of offset registers handled by the port
  localparam int NUM_OFS = 2;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  // pointer advance: empty -> full -> empty ...
  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

  // offset load: active-low load and write enable both asserted
  function automatic logic is_ofs_access(input logic ld_n, input logic en_n);
    return !ld_n && !en_n;
  endfunction

  // FIFO access: load released, enable asserted
  function automatic logic is_fifo_access(input logic ld_n, input logic en_n);
    return ld_n && !en_n;
  endfunction

endpackage

// File: rtl/offset_wr_side.sv
module offset_wr_side
  import offset_port_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 16,
  parameter logic [OW-1:0] EMPTY_DEF = '0,
  parameter logic [OW-1:0] FULL_DEF  = '0
) (
  input  logic                         clk,
  input  logic                         mrst_n,
  input  logic                         ld_n,
  input  logic                         wen_n,
  input  logic [OW-1:0]                wdata_lo,
  output logic [NUM_OFS-1:0][OW-1:0]   ofs,
  output logic [NUM_OFS-1:0]           vld,
  output ofs_sel_e                     wptr,
  output logic                         wr_evt,
  output logic                         fifo_wr
);

  localparam int LO_BITS = (DW < OW) ? DW : OW;

  assign wr_evt  = is_ofs_access(ld_n, wen_n);
  assign fifo_wr = is_fifo_access(ld_n, wen_n);

  // write pointer: advances on offset loads only
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      wptr <= SEL_EMPTY;
    end else if (wr_evt) begin
      wptr <= next_sel(wptr);
    end
  end

  // one storage register and validity bit per offset
  for (genvar gi = 0; gi < NUM_OFS; gi++) begin : g_ofs
    localparam logic [OW-1:0] DEF = (gi == 0) ? EMPTY_DEF : FULL_DEF;
    logic hit;
    assign hit = wr_evt && (int'(wptr) == gi);

    always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) begin
        ofs[gi] <= DEF;
      end else if (hit) begin
        ofs[gi] <= wdata_lo[LO_BITS-1:0];
      end
    end

    // a load into the first register opens a new pass: others become stale
    always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) begin
        vld[gi] <= 1'b1;
      end else if (hit) begin
        vld[gi] <= 1'b1;
      end else if (wr_evt && wptr == SEL_EMPTY && gi != 0) begin
        vld[gi] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/offset_rd_side.sv
module offset_rd_side
  import offset_port_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 16
) (
  input  logic                         clk,
  input  logic                         mrst_n,
  input  logic                         prst_n,
  input  logic                         ld_n,
  input  logic                         ren_n,
  input  logic [DW-1:0]                fifo_q,
  input  logic [NUM_OFS-1:0][OW-1:0]   ofs,
  output logic [DW-1:0]                q,
  output ofs_sel_e                     rptr,
  output logic                         rd_evt,
  output logic                         fifo_rd
);

  localparam int PAD = DW - OW;

  logic [OW-1:0] picked;
  logic [DW-1:0] picked_ext;

  // a partial reset blocks offset reads in its cycle
  assign rd_evt  = is_ofs_access(ld_n, ren_n) && prst_n;
  assign fifo_rd = is_fifo_access(ld_n, ren_n);

  assign picked = ofs[rptr];

  if (PAD > 0) begin : g_pad
    assign picked_ext = {{PAD{1'b0}}, picked};
  end else begin : g_nopad
    assign picked_ext = picked[DW-1:0];
  end

  // read pointer: advances on offset reads only
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      rptr <= SEL_EMPTY;
    end else if (rd_evt) begin
      rptr <= next_sel(rptr);
    end
  end

  // shared output register: partial reset, offset readback, FIFO word
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      q <= '0;
    end else if (!prst_n) begin
      q <= '0;
    end else if (rd_evt) begin
      q <= picked_ext;
    end else if (fifo_rd) begin
      q <= fifo_q;
    end
  end

endmodule

// File: rtl/offset_reg_port.sv
module offset_reg_port
  import offset_port_pkg::*;
#(
  parameter int DW = 16,
  parameter int OW = 16,
  parameter logic [OW-1:0] EMPTY_DEF = OW'(7),
  parameter logic [OW-1:0] FULL_DEF  = OW'(7)
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          ld_n,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] fifo_q,
  output logic [DW-1:0] q,
  output logic          fifo_wr,
  output logic          fifo_rd,
  output logic [OW-1:0] empty_ofs,
  output logic [OW-1:0] full_ofs,
  output logic          empty_ofs_vld,
  output logic          full_ofs_vld
);

  localparam int LO_BITS = (DW < OW) ? DW : OW;

  // named internal events for the checker
  ofs_sel_e                       wptr;
  ofs_sel_e                       rptr;
  logic                           wr_evt;
  logic                           rd_evt;
  logic [NUM_OFS-1:0][OW-1:0]     ofs;
  logic [NUM_OFS-1:0]             vld;
  logic [OW-1:0]                  wdata_lo;

  assign wdata_lo = OW'(wdata[LO_BITS-1:0]);

  offset_wr_side #(
    .DW(DW), .OW(OW), .EMPTY_DEF(EMPTY_DEF), .FULL_DEF(FULL_DEF)
  ) u_wr (
    .clk      (wr_clk),
    .mrst_n   (mrst_n),
    .ld_n     (ld_n),
    .wen_n    (wen_n),
    .wdata_lo (wdata_lo),
    .ofs      (ofs),
    .vld      (vld),
    .wptr     (wptr),
    .wr_evt   (wr_evt),
    .fifo_wr  (fifo_wr)
  );

  // offsets are quasi-static while read back from the other domain
  offset_rd_side #(
    .DW(DW), .OW(OW)
  ) u_rd (
    .clk     (rd_clk),
    .mrst_n  (mrst_n),
    .prst_n  (prst_n),
    .ld_n    (ld_n),
    .ren_n   (ren_n),
    .fifo_q  (fifo_q),
    .ofs     (ofs),
    .q       (q),
    .rptr    (rptr),
    .rd_evt  (rd_evt),
    .fifo_rd (fifo_rd)
  );

  assign empty_ofs     = ofs[SEL_EMPTY];
  assign full_ofs      = ofs[SEL_FULL];
  assign empty_ofs_vld = vld[SEL_EMPTY];
  assign full_ofs_vld  = vld[SEL_FULL];

endmodule

// File: rtl/offset_reg_port_chk.sv
module offset_reg_port_chk #(
  parameter int DW = 16,
  parameter int OW = 16
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic          fifo_rd,
  input logic          wptr,
  input logic          rptr,
  input logic [OW-1:0] empty_ofs,
  input logic [OW-1:0] full_ofs,
  input logic          full_vld,
  input logic [DW-1:0] q
);

  // R1: every offset load flips the write pointer
  assert_wptr_flip_R1: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    wr_evt |=> (wptr != $past(wptr)));

  // R3: no load, no write pointer movement
  assert_wptr_hold_R3: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    !wr_evt |=> $stable(wptr));

  // R2: every offset readback flips the read pointer
  assert_rptr_flip_R2: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    rd_evt |=> (rptr != $past(rptr)));

  // R3: no offset read, no read pointer movement
  assert_rptr_hold_R3: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    !rd_evt |=> $stable(rptr));

  // R6: offsets change only on a load
  assert_ofs_stable_R6: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    !wr_evt |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R8: loading the full offset makes it valid
  assert_full_vld_R8: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    (wr_evt && wptr) |=> full_vld);

  // R5: partial reset clears q and freezes the read pointer
  assert_prst_clear_R5: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    !prst_n |=> ((q == '0) && $stable(rptr)));

  // R9: q holds without a read
  assert_q_hold_R9: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (prst_n && !rd_evt && !fifo_rd) |=> $stable(q));

  if (DW > OW) begin : g_upper
    // R2: readback leaves the upper bits of q at zero
    assert_q_upper_zero_R2: assert property (@(posedge rd_clk) disable iff (!mrst_n)
      rd_evt |=> (q[DW-1:OW] == '0));
  end

endmodule

bind offset_reg_port offset_reg_port_chk #(.DW(DW), .OW(OW)) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .mrst_n    (mrst_n),
  .prst_n    (prst_n),
  .wr_evt    (wr_evt),
  .rd_evt    (rd_evt),
  .fifo_rd   (fifo_rd),
  .wptr      (wptr),
  .rptr      (rptr),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .full_vld  (full_ofs_vld),
  .q         (q)
);

// File: tb/test_offset_reg_port.sv
`timescale 1ns/1ps
module test_offset_reg_port;

  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW = 16;
  localparam int OW = 12;
  localparam int EDEF = 'h010;
  localparam int FDEF = 'h020;
  localparam int OMASK = (1 << OW) - 1;

  logic wr_clk = 0, rd_clk = 0;
  logic mrst_n = 0, prst_n = 1, ld_n = 1, wen_n = 1, ren_n = 1;
  logic [DW-1:0] wdata = '0, fifo_q = '0;
  logic [DW-1:0] q;
  logic fifo_wr, fifo_rd, empty_ofs_vld, full_ofs_vld;
  logic [OW-1:0] empty_ofs, full_ofs;

  int nchecks = 0, nerr = 0;
  bit run = 0;

  // behavioural reference state
  int m_ofs[2];
  bit m_vld[2];
  int m_wsel, m_rsel, m_q;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  offset_reg_port #(
    .DW(DW), .OW(OW), .EMPTY_DEF(OW'(EDEF)), .FULL_DEF(OW'(FDEF))
  ) i_offset_reg_port (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .ld_n(ld_n), .wen_n(wen_n), .ren_n(ren_n), .wdata(wdata), .fifo_q(fifo_q),
    .q(q), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .empty_ofs_vld(empty_ofs_vld), .full_ofs_vld(full_ofs_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // write-side model
  always @(posedge wr_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      m_ofs[0] = EDEF; m_ofs[1] = FDEF;
      m_vld[0] = 1; m_vld[1] = 1; m_wsel = 0;
    end else if (!ld_n && !wen_n) begin
      m_ofs[m_wsel] = int'(wdata) & OMASK;
      m_vld[m_wsel] = 1;
      if (m_wsel == 0) m_vld[1] = 0;
      m_wsel = 1 - m_wsel;
    end
  end

  // read-side model
  always @(posedge rd_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      m_q = 0; m_rsel = 0;
    end else if (!prst_n) begin
      m_q = 0;
    end else if (!ld_n && !ren_n) begin
      m_q = m_ofs[m_rsel];
      m_rsel = 1 - m_rsel;
    end else if (ld_n && !ren_n) begin
      m_q = int'(fifo_q);
    end
  end

  // per-cycle comparison, away from the active edges
  always @(negedge wr_clk) if (run) begin
    #1;
    chk("R1 empty_ofs", int'(empty_ofs), m_ofs[0]);
    chk("R1 full_ofs", int'(full_ofs), m_ofs[1]);
    chk("R8 empty_ofs_vld", int'(empty_ofs_vld), int'(m_vld[0]));
    chk("R8 full_ofs_vld", int'(full_ofs_vld), int'(m_vld[1]));
    chk("R6 fifo_wr", int'(fifo_wr), int'(ld_n && !wen_n));
  end

  always @(negedge rd_clk) if (run) begin
    #1;
    chk("R2 R7 R9 q", int'(q), m_q);
    chk("R7 fifo_rd", int'(fifo_rd), int'(ld_n && !ren_n));
  end

  task automatic wr_op(input logic ld, input logic wen, input logic [DW-1:0] d);
    @(negedge wr_clk);
    ld_n = ld; wen_n = wen; wdata = d;
  endtask

  task automatic rd_op(input logic ld, input logic ren, input logic [DW-1:0] fq, input logic pr);
    @(negedge rd_clk);
    ld_n = ld; ren_n = ren; fifo_q = fq; prst_n = pr;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    #32 mrst_n = 1;
    run = 1;
    // R4 reset state
    wr_op(1, 1, 0); #1;
    chk("R4 empty default", int'(empty_ofs), EDEF);
    chk("R4 full default", int'(full_ofs), FDEF);
    chk("R4 vld", int'({empty_ofs_vld, full_ofs_vld}), 3);
    chk("R4 q", int'(q), 0);

    // write phase: R1, R6, R8
    wr_op(0, 0, 16'hA123);
    wr_op(1, 1, 0); #1;
    chk("R1 first load to empty", int'(empty_ofs), 'h123);
    chk("R8 full invalid after new pass", int'(full_ofs_vld), 0);
    wr_op(1, 0, 16'h0BBB); #1;
    chk("R6 fifo_wr steering", int'(fifo_wr), 1);
    wr_op(0, 1, 0);
    wr_op(1, 1, 0); #1;
    chk("R6 pause keeps empty", int'(empty_ofs), 'h123);
    chk("R6 pause keeps full", int'(full_ofs), FDEF);
    wr_op(0, 0, 16'hF456);
    wr_op(1, 1, 0); #1;
    chk("R6 resume to full", int'(full_ofs), 'h456);
    chk("R8 full valid", int'(full_ofs_vld), 1);

    // read phase: R2, R7, R9
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R2 first read empty", int'(q), 'h123);
    rd_op(1, 0, 16'hCAFE, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R7 fifo word overwrites", int'(q), 'hCAFE);
    rd_op(0, 1, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R9 q held", int'(q), 'hCAFE);
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R7 resume reads full", int'(q), 'h456);
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R2 third read empty again", int'(q), 'h123);

    // R3 independence: wptr at empty, rptr at full
    wr_op(0, 0, 16'h0789);
    wr_op(1, 1, 0); #1;
    chk("R3 write unaffected by reads", int'(empty_ofs), 'h789);
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R3 read unaffected by writes", int'(q), 'h456);

    // R2 upper bits zero
    wr_op(0, 0, 16'hFFFF);
    wr_op(1, 1, 0); #1;
    chk("R1 masked load", int'(full_ofs), 'hFFF);
    rd_op(0, 0, 0, 1);
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R2 upper bits zero", int'(q), 'h0FFF);

    // R5 partial reset
    rd_op(0, 0, 0, 1);
    rd_op(0, 0, 0, 0);
    rd_op(1, 1, 0, 1); #1;
    chk("R5 q cleared", int'(q), 0);
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R5 rptr kept", int'(q), 'h0FFF);
    chk("R5 offsets kept", int'(empty_ofs), 'h789);

    // R4 master reset mid-run with both pointers away from empty
    wr_op(0, 0, 16'h0321);
    wr_op(1, 1, 0);
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1);
    @(negedge wr_clk); #2 mrst_n = 0;
    repeat (3) @(negedge wr_clk);
    #2 mrst_n = 1;
    wr_op(1, 1, 0); #1;
    chk("R4 offsets restored", int'(full_ofs), FDEF);
    chk("R4 q cleared", int'(q), 0);
    wr_op(0, 0, 16'h0AAA);
    wr_op(1, 1, 0); #1;
    chk("R4 wptr back to empty", int'(empty_ofs), 'hAAA);
    rd_op(0, 0, 0, 1);
    rd_op(1, 1, 0, 1); #1;
    chk("R4 rptr back to empty", int'(q), 'hAAA);

    repeat (4) @(negedge wr_clk);
    run = 0;
    #20;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule